// File: doc/BRIEF.md
# Serial Receive Flag and Mode Control

This block holds the control and status byte of a four-mode serial port and decides, for each frame the receive datapath completes, whether the frame is accepted. An accepted frame raises the receive flag and loads the received ninth bit. A frame with a bad stop bit may also raise a framing-error flag. A multiprocessor filter can drop frames in the 9-bit modes when their ninth bit is 0. In the 8-bit asynchronous mode it drops frames whose stop bit is bad. The same control bit instead selects the mode-0 shift-clock divisor.

Software reads and writes the byte through a one-cycle write strobe. Bit 7 of the byte has two meanings. An external select input chooses whether bit 7 reads and writes the upper mode bit or the framing-error flag. Both values are held in separate flip-flops, so changing the select input loses neither of them.

Top module: `uart_rx_ctl`

## Requirements
- R1: After reset every bit of `ctl_q` is 0, the framing-error flag is 0 and `shift_div` is 12.
- R2: Byte layout, from bit 7 down to bit 0: upper mode bit or framing error, lower mode bit, multiprocessor enable, receive enable, transmit bit 8, received bit 8, transmit flag, receive flag. The mode number is {bit 7 mode value, bit 6}. When `fe_sel` is 0, bit 7 reads and writes the stored upper mode bit. When `fe_sel` is 1, it reads and writes the framing-error flag. The other flip-flop keeps its value in both cases.
- R3: In modes 1, 2 and 3, an accepted-or-filtered frame with `frame_stop_ok` = 0 sets the framing-error flag. A frame counts here only if receive is enabled and the receive flag is clear. Mode-0 frames never set the framing-error flag.
- R4: Only a software write of 0 to bit 7 with `fe_sel` = 1 clears the framing-error flag. If a framing-error set falls in the same cycle as such a write, the flag ends up set.
- R5: In modes 2 and 3 with multiprocessor enable set, a frame whose ninth bit is 0 does not set the receive flag.
- R6: In mode 1 with multiprocessor enable set, a frame with an invalid stop bit does not set the receive flag.
- R7: With multiprocessor enable clear, every frame sets the receive flag in any mode, provided receive is enabled and the receive flag is clear. In mode 0 the frame sets the flag whatever the multiprocessor bit holds.
- R8: With receive enable clear, completed frames change neither the receive flag nor the framing-error flag.
- R9: When a frame sets the receive flag, bit 2 takes `frame_bit9` in modes 2 and 3 and `frame_stop_ok` in mode 1. In mode 0, bit 2 keeps its value.
- R10: A set receive flag stays set until software writes 0 to bit 0. A frame that arrives while the flag is set is ignored completely, including in the cycle of the clearing write.
- R11: `shift_div` is 12 when multiprocessor enable is 0 and 4 when it is 1.
- R12: Bits 6 to 0 are written from `wr_data` on a write strobe and read back unchanged unless a frame event overrides them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_sel | input | 1 | Bit 7 meaning: 0 upper mode bit, 1 framing error |
| wr_en | input | 1 | One-cycle software write strobe |
| wr_data | input | 8 | Byte written on the strobe |
| frame_done | input | 1 | One-cycle pulse when a frame has been received |
| frame_bit9 | input | 1 | Ninth data bit of that frame |
| frame_stop_ok | input | 1 | Stop bit of that frame was valid |
| ctl_q | output | 8 | Control and status byte as read |
| shift_div | output | DIV_W (4) | Mode-0 shift-clock divisor |

## Verification
Two events can fall in the same cycle: a software write strobe and a frame completion. The bench provokes this in two ways. First, it writes 0 to the framing-error bit while a bad-stop frame arrives, and expects the set to win. Second, it clears the receive flag while a frame arrives, and expects that frame to be ignored because the flag was still set when the frame was sampled. A behavioural model in the bench predicts the byte and the divisor every cycle from the rules above. Directed checks also compare fixed byte values at each step.

// File: rtl/uart_rx_ctl.sv
module uart_rx_ctl #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  localparam int DIV_W = $clog2(DIV_SLOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fe_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             frame_done,
  input  logic             frame_bit9,
  input  logic             frame_stop_ok,
  output logic [7:0]       ctl_q,
  output logic [DIV_W-1:0] shift_div
);

  logic sm0, sm1, mp, ren, tb8, rb8, ti, ri, fe;
  logic [1:0] mode;
  logic take, pass, hit, fe_hit;

  assign mode   = {sm0, sm1};
  assign take   = frame_done & ren & ~ri;
  assign pass   = (mode == 2'd0) | ~mp | ((mode == 2'd1) ? frame_stop_ok : frame_bit9);
  assign hit    = take & pass;
  assign fe_hit = take & (mode != 2'd0) & ~frame_stop_ok;

  assign ctl_q     = {fe_sel ? fe : sm0, sm1, mp, ren, tb8, rb8, ti, ri};
  assign shift_div = mp ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sm0, sm1, mp, ren, tb8, rb8, ti, ri} <= '0;
      fe <= 1'b0;
    end else begin
      if (wr_en) begin
        if (fe_sel) fe <= wr_data[7];
        else        sm0 <= wr_data[7];
        {sm1, mp, ren, tb8, rb8, ti, ri} <= wr_data[6:0];
      end
      if (fe_hit) fe <= 1'b1;
      if (hit) begin
        ri <= 1'b1;
        if (mode == 2'd1)  rb8 <= frame_stop_ok;
        else if (mode[1])  rb8 <= frame_bit9;
      end
    end
  end

  AST_FE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fe && !(wr_en && fe_sel && !wr_data[7]) |=> fe); // R4
  AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && ren && !ri && (sm0 || sm1) && !frame_stop_ok |=> fe); // R3
  AST_RI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !(wr_en && !wr_data[0]) |=> ri); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && ri && !wr_en |=> $stable(rb8) && $stable(fe)); // R10
  AST_NO_RI_9TH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && sm0 && mp && !frame_bit9 && !ri && !(wr_en && wr_data[0]) |=> !ri); // R5
  AST_NO_RI_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !sm0 && sm1 && mp && !frame_stop_ok && !ri && !(wr_en && wr_data[0]) |=> !ri); // R6
  AST_REN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !ren && !wr_en |=> $stable(ri) && $stable(fe)); // R8
  AST_RB8_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && ren && !ri && !sm0 && sm1 && (!mp || frame_stop_ok) |=> rb8 == $past(frame_stop_ok)); // R9

endmodule

// File: tb/uart_rx_ctl_tb_top.sv
module uart_rx_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe_sel = 1'b0, wr_en = 1'b0, frame_done = 1'b0, frame_bit9 = 1'b0, frame_stop_ok = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctl_q;
  logic [3:0] shift_div;

  always #10 clk = ~clk;

  uart_rx_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .fe_sel(fe_sel), .wr_en(wr_en), .wr_data(wr_data),
    .frame_done(frame_done), .frame_bit9(frame_bit9), .frame_stop_ok(frame_stop_ok),
    .ctl_q(ctl_q), .shift_div(shift_div)
  );

  int tests = 0, fails = 0, cyc = 0;
  string cur = "R1";

  bit m_sm0, m_sm1, m_mp, m_ren, m_tb8, m_rb8, m_ti, m_ri, m_fe;
  bit t_ok, p_ok;
  int md;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_sm0, m_sm1, m_mp, m_ren, m_tb8, m_rb8, m_ti, m_ri, m_fe} = '0;
    end else begin
      md   = (m_sm0 ? 2 : 0) + (m_sm1 ? 1 : 0);
      t_ok = frame_done && m_ren && !m_ri;
      if (md == 0 || !m_mp) p_ok = 1;
      else if (md == 1)     p_ok = frame_stop_ok;
      else                  p_ok = frame_bit9;
      if (wr_en) begin
        if (fe_sel) m_fe = wr_data[7]; else m_sm0 = wr_data[7];
        m_sm1 = wr_data[6]; m_mp = wr_data[5]; m_ren = wr_data[4];
        m_tb8 = wr_data[3]; m_rb8 = wr_data[2]; m_ti = wr_data[1]; m_ri = wr_data[0];
      end
      if (t_ok && md != 0 && !frame_stop_ok) m_fe = 1;
      if (t_ok && p_ok) begin
        m_ri = 1;
        if (md == 1) m_rb8 = frame_stop_ok;
        else if (md >= 2) m_rb8 = frame_bit9;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      tests++;
      if (ctl_q !== {fe_sel ? m_fe : m_sm0, m_sm1, m_mp, m_ren, m_tb8, m_rb8, m_ti, m_ri}) begin
        fails++;
        $display("FAIL %s model ctl_q actual %h expected %h", cur, ctl_q,
                 {fe_sel ? m_fe : m_sm0, m_sm1, m_mp, m_ren, m_tb8, m_rb8, m_ti, m_ri});
      end
      tests++;
      if (shift_div !== (m_mp ? 4'd4 : 4'd12)) begin
        fails++;
        $display("FAIL R11 model shift_div actual %0d expected %0d", shift_div, m_mp ? 4 : 12);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual %0d expected <50000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic frm(input logic b9, input logic st);
    @(negedge clk); frame_done = 1; frame_bit9 = b9; frame_stop_ok = st;
    @(negedge clk); frame_done = 0;
  endtask

  task automatic wr_frm(input logic [7:0] d, input logic b9, input logic st);
    @(negedge clk); wr_en = 1; wr_data = d; frame_done = 1; frame_bit9 = b9; frame_stop_ok = st;
    @(negedge clk); wr_en = 0; frame_done = 0;
  endtask

  task automatic sel(input logic s);
    fe_sel = s; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset byte", ctl_q, 8'h00);
    chk("R1 reset divisor", {4'h0, shift_div}, 8'd12);
    sel(1); chk("R1 reset fe", ctl_q, 8'h00); sel(0);

    cur = "R12"; wr(8'h7A); chk("R12 write readback", ctl_q, 8'h7A);
    cur = "R11"; chk("R11 divisor fast", {4'h0, shift_div}, 8'd4);

    cur = "R6"; frm(0, 0); chk("R6 mode1 bad stop no flag", ctl_q, 8'h7A);
    cur = "R2"; sel(1); chk("R2 R3 fe view", ctl_q, 8'hFA);
    sel(0); chk("R2 mode view kept", ctl_q, 8'h7A);

    cur = "R9"; frm(0, 1); chk("R9 mode1 rb8 takes stop", ctl_q, 8'h7F);
    cur = "R10"; frm(1, 0); chk("R10 busy frame ignored", ctl_q, 8'h7F);

    cur = "R4"; sel(1); chk("R4 fe still set", ctl_q, 8'hFF);
    wr(8'h7F); chk("R4 fe cleared by write", ctl_q, 8'h7F);
    wr(8'h7E); chk("R10 ri cleared by write", ctl_q, 8'h7E);
    wr_frm(8'h7E, 0, 0); chk("R4 set wins over clear", ctl_q, 8'hFE);
    wr(8'h7E); chk("R4 fe cleared", ctl_q, 8'h7E);

    cur = "R8"; wr(8'h4E); frm(1, 0); frm(0, 1); chk("R8 ren off no flags", ctl_q, 8'h4E);

    cur = "R7"; wr(8'h5E); frm(0, 0); chk("R7 R3 mp clear accepts bad stop", ctl_q, 8'hDB);
    wr(8'h58); chk("R4 R10 clear both", ctl_q, 8'h58);

    cur = "R2"; sel(0); wr(8'hF8); chk("R2 mode3 written", ctl_q, 8'hF8);
    sel(1); chk("R2 fe view independent", ctl_q, 8'h78); sel(0);

    cur = "R5"; frm(0, 1); chk("R5 mode3 bit9 low dropped", ctl_q, 8'hF8);
    frm(1, 1); chk("R5 R9 mode3 bit9 high accepted", ctl_q, 8'hFD);
    wr(8'hF8); wr(8'hB8); frm(0, 0); chk("R5 mode2 bit9 low dropped", ctl_q, 8'hB8);
    sel(1); chk("R3 mode2 bad stop sets fe", ctl_q, 8'hB8); sel(0);

    cur = "R7"; wr(8'h98); frm(0, 1); chk("R7 R9 mode2 mp clear rb8 bit9", ctl_q, 8'h99);
    cur = "R10"; wr_frm(8'h98, 1, 1); chk("R10 clear with frame ignored", ctl_q, 8'h98);

    cur = "R3"; sel(1); wr(8'h18); sel(0); wr(8'h1C); chk("R2 mode0 set", ctl_q, 8'h1C);
    chk("R11 divisor slow", {4'h0, shift_div}, 8'd12);
    frm(1, 0); chk("R9 mode0 rb8 kept", ctl_q, 8'h1D);
    sel(1); chk("R3 mode0 no fe", ctl_q, 8'h1D); sel(0);
    wr(8'h3C); chk("R11 divisor fast mode0", {4'h0, shift_div}, 8'd4);
    cur = "R7"; frm(0, 0); chk("R7 mode0 mp ignored", ctl_q, 8'h3D);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule